// File: doc/BRIEF.md
# Auto-Stepping Indirect Pointer Window

This block sits between a processor's indirect-addressing path and a single-port synchronous memory. A small fixed window of low memory holds pointer words with a side effect. When the processor asks for an indirect access through a location in the window, the block reads the stored pointer and steps it by one. It writes the stepped value back to the same location and then hands the stepped value on as the effective address. In the default layout the lower eight window locations step upward and the upper eight step downward. A build-time variant keeps only an upward-stepping range that starts lower in memory.

A pointer location outside the window costs one read. Its stored value is returned unchanged as the effective address, with no write cycle. Ordinary direct reads and writes, including those that touch window locations, go through to memory in the same cycle with no side effect while no indirect operation is in flight. Only one indirect operation is in flight at a time. `ind_ready` marks when a new one is accepted and when the direct path holds the memory port.

Top module: `autoidx_ptr_unit`

## Requirements
- R1: After reset `ind_ready` and `cpu_gnt` are 1, `ea_valid` is 0, and with `cpu_req` low `mem_req` is 0.
- R2: In the default layout, an indirect access through addresses 16..23 yields an effective address equal to the stored word plus one, modulo 2^16 (0xFFFF becomes 0x0000). The same value is written back to that address.
- R3: In the default layout, an indirect access through addresses 24..31 yields the stored word minus one, modulo 2^16 (0x0000 becomes 0xFFFF). The same value is written back to that address.
- R4: An indirect access through an address outside the window yields the stored word unchanged, issues exactly one memory read and no memory write, and leaves memory unchanged.
- R5: `ea_valid` is high for exactly one cycle. With acceptance at clock edge E0, `ea_valid` is high between edges E3 and E4 for a window address, after the write-back was issued between E2 and E3. For an address outside the window it is high between E2 and E3. The write-back targets the address that was read.
- R6: `ind_ready` drops on the cycle after a request is accepted and returns to 1 on the cycle after `ea_valid`.
- R7: While `ind_ready` is 1, `cpu_gnt` is 1 and the memory port mirrors `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` in the same cycle. `cpu_rdata` always equals `mem_rdata`. Direct reads and writes of window locations cause no stepping.
- R8: The stepped value written back is computed from the word read in the previous cycle: plus one for the upward range and minus one for the downward range.
- R9: With `WIN_BASE`=8, `INC_COUNT`=8 and `DEC_COUNT`=0, indirect access through 8..15 yields stored+1 with write-back, and every other address, including 16..31, behaves as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ind_req | input | 1 | Indirect request, accepted when `ind_ready` is 1 |
| ind_addr | input | AW | Address of the pointer word |
| ind_ready | output | 1 | Idle; a new indirect request is accepted |
| ea_valid | output | 1 | One-cycle strobe: effective address ready |
| ea_addr | output | DW | Effective address |
| cpu_req | input | 1 | Direct access request |
| cpu_we | input | 1 | Direct access is a write |
| cpu_addr | input | AW | Direct access address |
| cpu_wdata | input | DW | Direct write data |
| cpu_rdata | output | DW | Direct read data |
| cpu_gnt | output | 1 | Direct path owns the memory port this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read request |

## Verification
The bench targets the range edges: 15 and 16, 23 and 24, 31 and 32. A decoder that is off by one at any of these steps the wrong word, or steps it the wrong way. It also targets stored values 0xFFFF upward and 0x0000 downward, where a design without wrap logic, or one that is too wide, returns a wrong address. The bench counts memory writes and the cycles to the strobe. A design that writes back outside the window, flags valid before its write, or holds valid too long is caught at once. Direct reads of window words are repeated to show that they never step. A second instance in the single-range layout runs every operation, so a wrongly built variant shows up as bad addresses or stray writes.

// File: rtl/autoidx_pkg.sv
package autoidx_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_INC   = 2'd1,
    CLS_DEC   = 2'd2
  } adj_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_WBACK = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_e;

  // Classify a pointer address against an up range followed by a down range.
  function automatic adj_cls_e classify(
    input logic [31:0] a,
    input int unsigned base,
    input int unsigned n_inc,
    input int unsigned n_dec
  );
    logic [31:0] up_lo, up_hi, dn_hi;
    up_lo = base;
    up_hi = base + n_inc;
    dn_hi = up_hi + n_dec;
    if (a >= up_lo && a < up_hi) return CLS_INC;
    if (n_dec != 0 && a >= up_hi && a < dn_hi) return CLS_DEC;
    return CLS_PLAIN;
  endfunction

endpackage

// File: rtl/autoidx_decode.sv
module autoidx_decode
  import autoidx_pkg::*;
#(
  parameter int AW        = 16,
  parameter int WIN_BASE  = 16,
  parameter int INC_COUNT = 8,
  parameter int DEC_COUNT = 8
) (
  input  logic [AW-1:0] addr,
  output adj_cls_e      cls
);

  logic [31:0] addr_ext;
  assign addr_ext = 32'(addr);

  generate
    if (DEC_COUNT == 0) begin : g_up_only
      assign cls = classify(addr_ext, WIN_BASE, INC_COUNT, 0);
    end else begin : g_up_down
      assign cls = classify(addr_ext, WIN_BASE, INC_COUNT, DEC_COUNT);
    end
  endgenerate

endmodule

// File: rtl/autoidx_adjust.sv
module autoidx_adjust
  import autoidx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] word_in,
  input  adj_cls_e      cls,
  output logic [DW-1:0] word_out
);

  localparam logic [DW-1:0] STEP = DW'(1);

  function automatic logic [DW-1:0] step_word(input logic [DW-1:0] w, input adj_cls_e c);
    case (c)
      CLS_INC: return w + STEP;
      CLS_DEC: return w - STEP;
      default: return w;
    endcase
  endfunction

  assign word_out = step_word(word_in, cls);

endmodule

// File: rtl/autoidx_seq.sv
module autoidx_seq
  import autoidx_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ind_req,
  input  logic [AW-1:0] ind_addr,
  input  adj_cls_e      cls,
  input  logic [DW-1:0] stepped,
  output logic          ind_ready,
  output logic [AW-1:0] ptr_addr,
  output logic          seq_req,
  output logic          seq_we,
  output logic [DW-1:0] seq_wdata,
  output logic          ea_valid,
  output logic [DW-1:0] ea_addr,
  output logic          rd_fire,
  output logic          wb_fire
);

  seq_state_e state_q;
  logic [DW-1:0] value_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ptr_addr <= '0;
      value_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (ind_req) begin
            ptr_addr <= ind_addr;
            state_q  <= ST_READ;
          end
        end
        ST_READ: state_q <= ST_WAIT;
        ST_WAIT: begin
          value_q <= stepped;
          state_q <= (cls != CLS_PLAIN) ? ST_WBACK : ST_DONE;
        end
        ST_WBACK: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_fire   = (state_q == ST_READ);
  assign wb_fire   = (state_q == ST_WBACK);
  assign seq_req   = rd_fire | wb_fire;
  assign seq_we    = wb_fire;
  assign seq_wdata = value_q;
  assign ea_valid  = (state_q == ST_DONE);
  assign ea_addr   = value_q;
  assign ind_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/autoidx_port_mux.sv
module autoidx_port_mux #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          direct_own,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          seq_req,
  input  logic          seq_we,
  input  logic [AW-1:0] seq_addr,
  input  logic [DW-1:0] seq_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  always_comb begin
    if (direct_own) begin
      mem_req   = cpu_req;
      mem_we    = cpu_we;
      mem_addr  = cpu_addr;
      mem_wdata = cpu_wdata;
    end else begin
      mem_req   = seq_req;
      mem_we    = seq_we;
      mem_addr  = seq_addr;
      mem_wdata = seq_wdata;
    end
  end

endmodule

// File: rtl/autoidx_ptr_unit.sv
module autoidx_ptr_unit
  import autoidx_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int WIN_BASE  = 16,
  parameter int INC_COUNT = 8,
  parameter int DEC_COUNT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ind_req,
  input  logic [AW-1:0] ind_addr,
  output logic          ind_ready,
  output logic          ea_valid,
  output logic [DW-1:0] ea_addr,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_gnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  adj_cls_e      cls;
  logic [AW-1:0] ptr_addr;
  logic [DW-1:0] stepped;
  logic          seq_req, seq_we;
  logic [DW-1:0] seq_wdata;
  // Named events for the checker
  logic          rd_fire, wb_fire, op_adjust, op_dec;

  autoidx_decode #(
    .AW(AW), .WIN_BASE(WIN_BASE), .INC_COUNT(INC_COUNT), .DEC_COUNT(DEC_COUNT)
  ) u_decode (
    .addr (ptr_addr),
    .cls  (cls)
  );

  autoidx_adjust #(.DW(DW)) u_adjust (
    .word_in  (mem_rdata),
    .cls      (cls),
    .word_out (stepped)
  );

  autoidx_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ind_req   (ind_req),
    .ind_addr  (ind_addr),
    .cls       (cls),
    .stepped   (stepped),
    .ind_ready (ind_ready),
    .ptr_addr  (ptr_addr),
    .seq_req   (seq_req),
    .seq_we    (seq_we),
    .seq_wdata (seq_wdata),
    .ea_valid  (ea_valid),
    .ea_addr   (ea_addr),
    .rd_fire   (rd_fire),
    .wb_fire   (wb_fire)
  );

  autoidx_port_mux #(.AW(AW), .DW(DW)) u_mux (
    .direct_own (ind_ready),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .seq_req    (seq_req),
    .seq_we     (seq_we),
    .seq_addr   (ptr_addr),
    .seq_wdata  (seq_wdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  assign op_adjust = (cls != CLS_PLAIN);
  assign op_dec    = (cls == CLS_DEC);
  assign cpu_gnt   = ind_ready;
  assign cpu_rdata = mem_rdata;

endmodule

// File: rtl/autoidx_ptr_unit_chk.sv
module autoidx_ptr_unit_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ind_req,
  input logic          ind_ready,
  input logic          ea_valid,
  input logic          cpu_req,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic          rd_fire,
  input logic          wb_fire,
  input logic          op_adjust,
  input logic          op_dec
);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |=> !ea_valid); // R5
  AST_WB_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && op_adjust) |-> $past(wb_fire)); // R5
  AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> (mem_addr == $past(mem_addr, 2))); // R5
  AST_NO_WB_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> op_adjust); // R4
  AST_PLAIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && !op_adjust) |-> $past(rd_fire, 2)); // R4
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && !op_dec) |-> (mem_wdata == DW'($past(mem_rdata) + 1'b1))); // R8
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && op_dec) |-> (mem_wdata == DW'($past(mem_rdata) - 1'b1))); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_req && ind_ready) |=> !ind_ready); // R6
  AST_DIRECT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    ind_ready |-> (mem_req == cpu_req)); // R7

endmodule

bind autoidx_ptr_unit autoidx_ptr_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ind_req   (ind_req),
  .ind_ready (ind_ready),
  .ea_valid  (ea_valid),
  .cpu_req   (cpu_req),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .rd_fire   (rd_fire),
  .wb_fire   (wb_fire),
  .op_adjust (op_adjust),
  .op_dec    (op_dec)
);

// File: tb/autoidx_ptr_unit_test.sv
module autoidx_tb_ram #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [64];
  always @(posedge clk) begin
    if (req) begin
      if (we) mem[addr[5:0]] <= wdata;
      else    rdata <= mem[addr[5:0]];
    end
  end
endmodule

module autoidx_ptr_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ind_req = 1'b0;
  logic [AW-1:0] ind_addr = '0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;

  logic rdy0, v0, gnt0, mreq0, mwe0;
  logic [DW-1:0] ea0, crd0, mwd0, mrd0;
  logic [AW-1:0] maddr0;
  logic rdy1, v1, gnt1, mreq1, mwe1;
  logic [DW-1:0] ea1, crd1, mwd1, mrd1;
  logic [AW-1:0] maddr1;

  int checks = 0, errors = 0;
  int wr0 = 0, wr1 = 0;
  bit done_flag = 0;
  logic [DW-1:0] exp0 [64];
  logic [DW-1:0] exp1 [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  autoidx_ptr_unit uut (
    .clk(clk), .rst_n(rst_n), .ind_req(ind_req), .ind_addr(ind_addr),
    .ind_ready(rdy0), .ea_valid(v0), .ea_addr(ea0),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(crd0), .cpu_gnt(gnt0),
    .mem_req(mreq0), .mem_we(mwe0), .mem_addr(maddr0), .mem_wdata(mwd0), .mem_rdata(mrd0)
  );
  autoidx_tb_ram #(.AW(AW), .DW(DW)) ram0 (
    .clk(clk), .req(mreq0), .we(mwe0), .addr(maddr0), .wdata(mwd0), .rdata(mrd0)
  );

  autoidx_ptr_unit #(.WIN_BASE(8), .INC_COUNT(8), .DEC_COUNT(0)) uut_var (
    .clk(clk), .rst_n(rst_n), .ind_req(ind_req), .ind_addr(ind_addr),
    .ind_ready(rdy1), .ea_valid(v1), .ea_addr(ea1),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(crd1), .cpu_gnt(gnt1),
    .mem_req(mreq1), .mem_we(mwe1), .mem_addr(maddr1), .mem_wdata(mwd1), .mem_rdata(mrd1)
  );
  autoidx_tb_ram #(.AW(AW), .DW(DW)) ram1 (
    .clk(clk), .req(mreq1), .we(mwe1), .addr(maddr1), .wdata(mwd1), .rdata(mrd1)
  );

  // Count write cycles issued by the units themselves
  always @(posedge clk) begin
    if (mreq0 && mwe0 && !cpu_req) wr0 <= wr0 + 1;
    if (mreq1 && mwe1 && !cpu_req) wr1 <= wr1 + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Reference: class 0 plain, 1 up, 2 down
  function automatic int ref_class(input bit variant, input logic [AW-1:0] a);
    if (variant) return (a >= 8 && a <= 15) ? 1 : 0;
    if (a >= 16 && a <= 23) return 1;
    if (a >= 24 && a <= 31) return 2;
    return 0;
  endfunction

  function automatic logic [DW-1:0] ref_ea(input int c, input logic [DW-1:0] w);
    if (c == 1) return w + 16'h0001;
    if (c == 2) return w + 16'hFFFF;
    return w;
  endfunction

  function automatic string tag_of(input bit variant, input int c);
    if (variant) return "R9";
    return (c == 1) ? "R2" : (c == 2) ? "R3" : "R4";
  endfunction

  task automatic dwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    exp0[a[5:0]] = d;
    exp1[a[5:0]] = d;
  endtask

  task automatic dread(input logic [AW-1:0] a);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a;
    #1;
    chk(mreq0 && !mwe0 && maddr0 == a && gnt0, "R7 mirror", {16'h0, maddr0}, {16'h0, a});
    @(negedge clk);
    cpu_req = 0;
    chk(crd0 == exp0[a[5:0]], "R7 read", {16'h0, crd0}, {16'h0, exp0[a[5:0]]});
    chk(crd1 == exp1[a[5:0]], "R7 read var", {16'h0, crd1}, {16'h0, exp1[a[5:0]]});
  endtask

  task automatic do_ind(input logic [AW-1:0] a);
    int c0, c1, lat0, lat1, nv0, nv1;
    logic [DW-1:0] e0, e1, got0, got1;
    c0 = ref_class(0, a); c1 = ref_class(1, a);
    e0 = ref_ea(c0, exp0[a[5:0]]); e1 = ref_ea(c1, exp1[a[5:0]]);
    lat0 = 0; lat1 = 0; nv0 = 0; nv1 = 0; got0 = '0; got1 = '0;
    @(negedge clk);
    wr0 = 0; wr1 = 0;
    ind_req = 1; ind_addr = a;
    @(negedge clk);
    ind_req = 0;
    chk(!rdy0 && !rdy1, "R6 busy", {30'h0, rdy0, rdy1}, 32'h0);
    for (int n = 1; n <= 6; n++) begin
      if (v0) begin nv0++; if (lat0 == 0) begin lat0 = n; got0 = ea0; end end
      if (v1) begin nv1++; if (lat1 == 0) begin lat1 = n; got1 = ea1; end end
      if (n == 5) chk(rdy0 && rdy1, "R6 ready again", {30'h0, rdy0, rdy1}, 32'h3);
      @(negedge clk);
    end
    chk(got0 == e0, tag_of(0, c0), {16'h0, got0}, {16'h0, e0});
    chk(got1 == e1, tag_of(1, c1), {16'h0, got1}, {16'h0, e1});
    chk(nv0 == 1 && nv1 == 1, "R5 one-cycle valid", nv0 * 16 + nv1, 32'h11);
    chk(lat0 == ((c0 != 0) ? 4 : 3), "R5 latency", lat0, (c0 != 0) ? 4 : 3);
    chk(lat1 == ((c1 != 0) ? 4 : 3), "R5 latency var", lat1, (c1 != 0) ? 4 : 3);
    chk(wr0 == ((c0 != 0) ? 1 : 0), (c0 != 0) ? "R2 write-back" : "R4 no write", wr0, (c0 != 0) ? 1 : 0);
    chk(wr1 == ((c1 != 0) ? 1 : 0), "R9 write count", wr1, (c1 != 0) ? 1 : 0);
    exp0[a[5:0]] = e0;
    exp1[a[5:0]] = e1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rdy0 && gnt0 && !v0 && !mreq0, "R1", {28'h0, rdy0, gnt0, v0, mreq0}, 32'hC);
    chk(rdy1 && gnt1 && !v1 && !mreq1, "R1 var", {28'h0, rdy1, gnt1, v1, mreq1}, 32'hC);

    for (int i = 0; i < 48; i++) dwrite(AW'(i), DW'(i * 257 + 3));
    dwrite(16, 16'hFFFF);
    dwrite(24, 16'h0000);
    dwrite(8,  16'h00FF);
    dwrite(15, 16'h4444);
    dwrite(23, 16'h1234);
    dwrite(31, 16'h8000);
    dwrite(32, 16'h5555);

    // Boundaries and wrap
    do_ind(16);  // R2 wrap to 0
    do_ind(24);  // R3 wrap to FFFF
    do_ind(8);   // R9 step in variant, plain in default
    do_ind(15);
    do_ind(23);
    do_ind(31);
    do_ind(32);  // R4
    do_ind(0);
    do_ind(16);
    // R7: direct reads never step the word
    dread(16); dread(16); dread(24); dread(24); dread(8); dread(8);
    dread(32);

    for (int k = 0; k < 150; k++) begin
      logic [AW-1:0] a;
      int op;
      a = AW'($urandom % 48);
      op = $urandom % 3;
      if (op == 0) do_ind(a);
      else if (op == 1) dread(a);
      else dwrite(a, DW'($urandom));
    end
    for (int i = 0; i < 48; i++) dread(AW'(i));
    finish_run();
  end
endmodule